// File: doc/BRIEF.md
# Byte Adder-Subtractor with Selectable Carry-In

This block is the arithmetic slice of a small byte-wide datapath. It adds or subtracts two 8-bit operands in one combinational pass and keeps a carry flag and a signed-overflow flag in registers. A 3-bit operation code chooses the carry-in and decides whether B is inverted. Subtraction uses the same adder: B is inverted and the carry-in is forced to 1, or the carry-in is taken from the stored flag.

Numbers wider than one byte are processed one byte per step, starting with the least significant byte. The first step uses a forced carry-in (plain add or plain subtract). Each later step uses the stored carry (add-with-carry or subtract-with-borrow). Two flag commands load the carry flag with 0 or with 1 directly. The flags change only on a clock edge where `exec` is high.

Top module: `byte_addsub`

## Requirements
- R1: Code `op=3'b000` (plain add) gives {cout,sum} = A + B + 0, whatever the stored carry.
- R2: Code `op=3'b001` (add with carry) gives {cout,sum} = A + B + carry_q. On an edge with `exec` high, any code with op[2]=0 loads `carry_q` with `cout` and `ovf_q` with `ovf`.
- R3: Code `op=3'b010` (plain subtract) gives {cout,sum} = A + ~B + 1, whatever the stored carry. `cout` is therefore 1 when A >= B, taken as unsigned values.
- R4: Code `op=3'b011` (subtract with borrow) gives {cout,sum} = A + ~B + carry_q.
- R5: `ovf` is 1 only in two cases. The first: bit 7 of A is 0, bit 7 of the B value fed to the adder (inverted when op[1]=1) is 0, and sum bit 7 is 1. The second: those two operand bits are both 1 and sum bit 7 is 0.
- R6: Codes with op[2]=1 are flag commands. On an edge with `exec` high they load `carry_q` with op[0] (so `3'b100` clears it and `3'b101` sets it) and leave `ovf_q` unchanged. The combinational outputs still follow op[1:0].
- R7: With `exec` low, neither `carry_q` nor `ovf_q` changes at the clock edge, whatever the op code.
- R8: While `rst_n` is low, `carry_q` and `ovf_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec | input | 1 | Allows the flags to update at this edge |
| op | input | 3 | Operation code |
| a | input | 8 | Operand A |
| b | input | 8 | Operand B |
| sum | output | 8 | Result byte |
| cout | output | 1 | Carry out of bit 7 |
| ovf | output | 1 | Two's-complement overflow of this pass |
| carry_q | output | 1 | Stored carry flag |
| ovf_q | output | 1 | Stored overflow flag |

## Verification
Some cases are hard to reach from the ports. The forced carry-in codes must be shown to ignore a stored carry of 1 for plain add, and a stored carry of 0 for plain subtract. The stimulus therefore runs a flag command first, to put the opposite value in the register, and then issues the forced-carry operation.

Overflow in subtraction depends on the inverted sign bit of B. Directed operand pairs such as 0x80 minus 0x01 are used to trigger it. Two-byte add and subtract chains show that the carry passes from the low-byte step to the high-byte step. A long random run then mixes operations with `exec` dropped on some cycles, so that the hold rule is exercised as well.

// File: rtl/byte_addsub.sv
module byte_addsub #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         exec,
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf,
  output logic         carry_q,
  output logic         ovf_q
);

  // index {a_msb, b_fed_msb, sum_msb}: entries 3'b001 and 3'b110 signal overflow
  localparam logic [7:0] OVF_TABLE = 8'b0100_0010;

  logic         inv_b;
  logic         use_flag;
  logic         cin;
  logic [W-1:0] b_fed;
  logic [2:0]   ovf_idx;

  assign inv_b    = op[1];
  assign use_flag = op[0];
  assign b_fed    = inv_b ? ~b : b;
  assign cin      = use_flag ? carry_q : inv_b;

  assign {cout, sum} = {1'b0, a} + {1'b0, b_fed} + {{W{1'b0}}, cin};

  assign ovf_idx = {a[W-1], b_fed[W-1], sum[W-1]};
  assign ovf     = OVF_TABLE[ovf_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (exec) begin
      if (op[2]) begin
        carry_q <= op[0];
      end else begin
        carry_q <= cout;
        ovf_q   <= ovf;
      end
    end
  end

endmodule

module byte_addsub_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         exec,
  input logic [2:0]   op,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [W-1:0] sum,
  input logic         cout,
  input logic         ovf,
  input logic         carry_q,
  input logic         ovf_q
);

  logic         sgn_b;
  logic [W:0]   plain_add;
  logic [W:0]   plain_sub;

  assign sgn_b     = op[1] ? ~b[W-1] : b[W-1];
  assign plain_add = {1'b0, a} + {1'b0, b};
  assign plain_sub = {1'b0, a} + {1'b0, ~b} + (W+1)'(1);

  a_r1_add_forced_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op[1:0] == 2'b00) |-> ({cout, sum} == plain_add));

  a_r3_sub_forced_one: assert property (@(posedge clk) disable iff (!rst_n)
    (op[1:0] == 2'b10) |-> ({cout, sum} == plain_sub));

  a_r5_overflow_rule: assert property (@(posedge clk) disable iff (!rst_n)
    ovf == ((a[W-1] == sgn_b) && (sum[W-1] != a[W-1])));

  a_r2_flags_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !op[2]) |=> (carry_q == $past(cout)) && (ovf_q == $past(ovf)));

  a_r6_clear_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op[2] && !op[0]) |=> !carry_q && $stable(ovf_q));

  a_r6_set_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op[2] && op[0]) |=> carry_q && $stable(ovf_q));

  a_r7_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(carry_q) && $stable(ovf_q));

endmodule

bind byte_addsub byte_addsub_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .a(a), .b(b),
  .sum(sum), .cout(cout), .ovf(ovf), .carry_q(carry_q), .ovf_q(ovf_q)
);

// File: tb/byte_addsub_tb_top.sv
module byte_addsub_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec = 1'b0;
  logic [2:0] op = 3'b000;
  logic [7:0] a = 8'h00;
  logic [7:0] b = 8'h00;
  logic [7:0] sum;
  logic       cout, ovf, carry_q, ovf_q;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  byte_addsub dut_i (
    .clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .a(a), .b(b),
    .sum(sum), .cout(cout), .ovf(ovf), .carry_q(carry_q), .ovf_q(ovf_q)
  );

  typedef struct {
    logic [7:0] e_sum;
    logic       e_cout;
    logic       e_ovf;
    logic       e_cq;
    logic       e_vq;
    string      tag;
  } exp_t;

  exp_t sb[$];
  logic m_c = 1'b0;
  logic m_v = 1'b0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [7:0] x, input logic [7:0] y,
                       input logic ex, input string tag);
    exp_t it;
    logic [7:0] yb;
    logic       ci;
    logic [8:0] full;
    @(negedge clk);
    op = o; a = x; b = y; exec = ex;
    yb   = o[1] ? ~y : y;
    ci   = o[0] ? m_c : o[1];
    full = {1'b0, x} + {1'b0, yb} + {8'd0, ci};
    it.e_sum  = full[7:0];
    it.e_cout = full[8];
    it.e_ovf  = (x[7] == yb[7]) && (full[7] != x[7]);
    if (ex) begin
      if (o[2]) m_c = o[0];
      else begin
        m_c = it.e_cout;
        m_v = it.e_ovf;
      end
    end
    it.e_cq = m_c;
    it.e_vq = m_v;
    it.tag  = tag;
    sb.push_back(it);
  endtask

  initial begin : monitor
    exp_t it;
    forever begin
      @(negedge clk);
      #5;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        check(it.tag, "sum", sum, it.e_sum);
        check(it.tag, "cout", cout, it.e_cout);
        check(it.tag, "ovf", ovf, it.e_ovf);
        @(posedge clk);
        #5;
        check(it.tag, "carry_q", carry_q, it.e_cq);
        check(it.tag, "ovf_q", ovf_q, it.e_vq);
      end
    end
  end

  initial begin : watchdog
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    check("R8", "carry_q in reset", carry_q, 0);
    check("R8", "ovf_q in reset", ovf_q, 0);
    rst_n = 1'b1;
    #5;
    check("R8", "carry_q after reset", carry_q, 0);
    check("R8", "ovf_q after reset", ovf_q, 0);

    apply(3'b101, 8'h00, 8'h00, 1'b1, "R6 set carry");
    apply(3'b000, 8'h1C, 8'h1C, 1'b1, "R1 add ignores carry 1");
    apply(3'b101, 8'h00, 8'h00, 1'b1, "R6 set carry");
    apply(3'b001, 8'hF0, 8'h0F, 1'b1, "R2 adc carry 1");
    apply(3'b100, 8'h00, 8'h00, 1'b1, "R6 clear carry");
    apply(3'b010, 8'h1C, 8'h1B, 1'b1, "R3 sub ignores carry 0");
    apply(3'b100, 8'h00, 8'h00, 1'b1, "R6 clear carry");
    apply(3'b011, 8'h10, 8'h01, 1'b1, "R4 sbc borrow");
    apply(3'b000, 8'h7F, 8'h7F, 1'b1, "R5 pos+pos overflow");
    apply(3'b000, 8'h80, 8'h80, 1'b1, "R5 neg+neg overflow");
    apply(3'b010, 8'h80, 8'h01, 1'b1, "R5 sub overflow");
    apply(3'b010, 8'h05, 8'h07, 1'b1, "R3 sub borrow out");
    apply(3'b101, 8'h00, 8'h00, 1'b1, "R6 set keeps ovf_q");
    apply(3'b000, 8'hFF, 8'h01, 1'b0, "R7 hold on add");
    apply(3'b100, 8'h00, 8'h00, 1'b0, "R7 hold on clear");
    // two-byte chains: 0x01FF + 0x0001, 0x0200 - 0x0001
    apply(3'b000, 8'hFF, 8'h01, 1'b1, "R2 chain low");
    apply(3'b001, 8'h01, 8'h00, 1'b1, "R2 chain high");
    apply(3'b010, 8'h00, 8'h01, 1'b1, "R4 chain low");
    apply(3'b011, 8'h02, 8'h00, 1'b1, "R4 chain high");

    for (int i = 0; i < 400; i++) begin
      logic [2:0] o;
      int k;
      k = $urandom % 6;
      o = (k < 4) ? 3'(k) : ((k == 4) ? 3'b100 : 3'b101);
      apply(o, 8'($urandom), 8'($urandom), ($urandom % 5) != 0, "R7 random mix");
    end

    @(negedge clk);
    exec = 1'b0;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule